// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave Model

This block models a small, electrically programmed memory that sits behind a three-wire serial port: a select line, a serial clock and a data input, with one data output that has its own enable so that it can float. The three pins are brought into the system clock domain, and their edges drive a frame decoder. Each frame opens with a 1 start bit. Then come a two-bit opcode, a six-bit word address and, for commands that store something, a sixteen-bit data word. The array holds 64 words of 16 bits, kept in registers.

A latch gates every command that changes the array, and reset clears it. Reads work whatever its state. A store begins only when the select line falls in a narrow window after the final bit of the frame. A counter of system clocks then times the store. While it runs, the block ignores the serial clock and any new frame. During that time the output reports busy whenever the device is selected, and it reports ready once the count has expired.

Top module: `mw_eeprom`

## Requirements
- R1: After reset, every word reads 0xFFFF, the write-enable latch is cleared and the data output is not enabled.
- R2: While the latch is clear, a single-word write (opcode 01), a word erase (opcode 11), a fill-all (opcode 00, address bits [5:4]=01) and an erase-all (opcode 00, address bits [5:4]=10) leave the array unchanged.
- R3: Opcode 00 with address bits [5:4]=11 sets the latch. Opcode 00 with address bits [5:4]=00 clears it, and after that every array-changing command is blocked again.
- R4: A read (opcode 10) drives a 0 once the last address bit has been sampled. The sixteen data bits then follow MSB first, one bit per rising serial-clock edge. A read returns stored data whether the latch is set or clear.
- R5: A frame of start 1, opcode 01, address MSB first and data MSB first stores the data at the address. This happens when the select line falls after the last data bit and before the next rising serial clock.
- R6: If the select line falls before the last data bit, or after a further rising serial-clock edge, the word is left unchanged.
- R7: A word erase sets the addressed word to 0xFFFF.
- R8: Erase-all sets every word to 0xFFFF. Fill-all writes the supplied data word into every word, and no erase is needed beforehand.
- R9: While a store is running and the device is selected, the data output drives 0. Once CYCLE_CLKS system clocks have passed, it drives 1.
- R10: The data output enable follows the select line, delayed by the two-stage input synchronizer. When the device is not selected, the output is undriven.
- R11: Any frame that arrives while a store is running, including one that would clear the latch, has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all pins are sampled in this domain |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_i | input | 1 | Device select, active high |
| sk_i | input | 1 | Serial clock; the frame advances on its rising edges |
| di_i | input | 1 | Serial data in |
| do_o | output | 1 | Serial data out: read bits, or busy (0) / ready (1) status |
| do_oe_o | output | 1 | Output enable for do_o; low means high-impedance |

## Verification
The hardest condition to produce is a frame that arrives in the middle of a self-timed store. The stimulus has to end a write correctly and then quickly select the device again. It then sends a latch-clear command that must finish inside the busy window. Because the latch is never observable directly, a write issued after the window shows whether the latch-clear was ignored. Stores that miss the timing window are produced in two ways. In one, the select line drops one data bit early. In the other, one extra serial-clock pulse is sent before the select line drops. Each case is followed by a read of the target word.

// File: rtl/mw_pkg.sv
package mw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_ADDR,
    ST_DATA,
    ST_ARMED,
    ST_READ,
    ST_DONE
  } fr_state_t;

  typedef enum logic [1:0] {
    OP_CTRL  = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_ERASE = 2'b11
  } opcode_t;

  typedef enum logic [1:0] {
    PG_WRITE,
    PG_ERASE,
    PG_FILL,
    PG_WIPE
  } prog_t;

  localparam logic [1:0] CTL_WEN_SET = 2'b11;
  localparam logic [1:0] CTL_WEN_CLR = 2'b00;
  localparam logic [1:0] CTL_WIPE    = 2'b10;
  localparam logic [1:0] CTL_FILL    = 2'b01;

endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  for (genvar gb = 0; gb < WIDTH; gb++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_n;

    if (STAGES > 1) begin : g_multi
      assign chain_n = {chain_q[STAGES-2:0], async_i[gb]};
    end else begin : g_single
      assign chain_n = async_i[gb];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= chain_n;
    end

    assign sync_o[gb] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/mw_cycle_timer.sv
module mw_cycle_timer #(
  parameter int CYCLES = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o
);

  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_n;
  logic          cnt_en;

  always_comb begin
    cnt_en = start_i || (cnt_q != '0);
    cnt_n  = start_i ? CW'(CYCLES) : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_n;
  end

  assign busy_o = (cnt_q != '0);

endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom
  import mw_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 16,
  parameter int CYCLE_CLKS = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_i,
  input  logic sk_i,
  input  logic di_i,
  output logic do_o,
  output logic do_oe_o
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int MAXF  = (DATA_W > ADDR_W) ? DATA_W : ADDR_W;
  localparam int CNT_W = $clog2(MAXF);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe_q;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  // pin synchronizer and edge detection
  logic [2:0] pins_s;
  logic       cs_s, sk_s, di_s;
  logic       cs_d_q, sk_d_q;
  logic       cs_fall, sk_rise;

  mw_sync #(.WIDTH(3), .STAGES(2)) u_sync (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .async_i({cs_i, sk_i, di_i}),
    .sync_o (pins_s)
  );

  assign {cs_s, sk_s, di_s} = pins_s;
  assign cs_fall = cs_d_q && !cs_s;
  assign sk_rise = sk_s && !sk_d_q;

  // self-timed store
  logic cyc_start;
  logic busy;

  mw_cycle_timer #(.CYCLES(CYCLE_CLKS)) u_timer (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .start_i(cyc_start),
    .busy_o (busy)
  );

  // frame state
  fr_state_t          st_q, st_n;
  logic [CNT_W-1:0]   cnt_q, cnt_n;
  logic [1:0]         op_q, op_n;
  logic [ADDR_W-1:0]  addr_q, addr_n;
  logic [DATA_W-1:0]  data_q, data_n;
  logic [DATA_W:0]    rd_sr_q, rd_sr_n;
  prog_t              pg_q, pg_n;
  logic               wen_q, wen_n;
  logic [DATA_W-1:0]  mem_rd [DEPTH];

  always_comb begin
    st_n      = st_q;
    cnt_n     = cnt_q;
    op_n      = op_q;
    addr_n    = addr_q;
    data_n    = data_q;
    rd_sr_n   = rd_sr_q;
    pg_n      = pg_q;
    wen_n     = wen_q;
    cyc_start = 1'b0;
    if (!cs_s) begin
      st_n      = ST_IDLE;
      cyc_start = (st_q == ST_ARMED) && cs_fall && wen_q;
    end else if (busy) begin
      st_n = ST_IDLE;
    end else if (sk_rise) begin
      unique case (st_q)
        ST_IDLE: if (di_s) begin
          st_n  = ST_OPC;
          cnt_n = '0;
        end
        ST_OPC: begin
          op_n = {op_q[0], di_s};
          if (cnt_q == CNT_W'(1)) begin
            st_n  = ST_ADDR;
            cnt_n = '0;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        ST_ADDR: begin
          addr_n = {addr_q[ADDR_W-2:0], di_s};
          cnt_n  = cnt_q + 1'b1;
          if (cnt_q == CNT_W'(ADDR_W - 1)) begin
            cnt_n = '0;
            unique case (op_q)
              OP_READ: begin
                st_n    = ST_READ;
                rd_sr_n = {1'b0, mem_rd[addr_n]};
              end
              OP_WRITE: begin
                st_n = ST_DATA;
                pg_n = PG_WRITE;
              end
              OP_ERASE: begin
                st_n = ST_ARMED;
                pg_n = PG_ERASE;
              end
              default: begin
                unique case (addr_n[ADDR_W-1 -: 2])
                  CTL_WEN_SET: begin wen_n = 1'b1; st_n = ST_DONE; end
                  CTL_WEN_CLR: begin wen_n = 1'b0; st_n = ST_DONE; end
                  CTL_WIPE:    begin pg_n = PG_WIPE; st_n = ST_ARMED; end
                  default:     begin pg_n = PG_FILL; st_n = ST_DATA; end
                endcase
              end
            endcase
          end
        end
        ST_DATA: begin
          data_n = {data_q[DATA_W-2:0], di_s};
          cnt_n  = cnt_q + 1'b1;
          if (cnt_q == CNT_W'(DATA_W - 1)) st_n = ST_ARMED;
        end
        ST_ARMED: st_n = ST_DONE;
        ST_READ:  rd_sr_n = {rd_sr_q[DATA_W-1:0], 1'b0};
        default:  st_n = st_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      op_q    <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      rd_sr_q <= '0;
      pg_q    <= PG_WRITE;
      wen_q   <= 1'b0;
      cs_d_q  <= 1'b0;
      sk_d_q  <= 1'b0;
    end else begin
      st_q    <= st_n;
      cnt_q   <= cnt_n;
      op_q    <= op_n;
      addr_q  <= addr_n;
      data_q  <= data_n;
      rd_sr_q <= rd_sr_n;
      pg_q    <= pg_n;
      wen_q   <= wen_n;
      cs_d_q  <= cs_s;
      sk_d_q  <= sk_s;
    end
  end

  // storage array
  logic              pg_all;
  logic [DATA_W-1:0] prog_word;
  assign pg_all    = (pg_q == PG_FILL) || (pg_q == PG_WIPE);
  assign prog_word = ((pg_q == PG_WRITE) || (pg_q == PG_FILL)) ? data_q : '1;

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_word
    logic [DATA_W-1:0] word_q;
    logic              word_we;
    assign word_we = cyc_start && (pg_all || (addr_q == ADDR_W'(gi)));
    always_ff @(posedge clk or negedge rst_core_n) begin
      if (!rst_core_n)  word_q <= '1;
      else if (word_we) word_q <= prog_word;
    end
    assign mem_rd[gi] = word_q;
  end

  // serial output
  assign do_oe_o = cs_s;
  assign do_o    = busy ? 1'b0 : ((st_q == ST_READ) ? rd_sr_q[DATA_W] : 1'b1);

endmodule

// File: rtl/mw_eeprom_chk.sv
module mw_eeprom_chk (
  input logic clk,
  input logic rst_n,
  input logic do_o,
  input logic do_oe_o,
  input logic busy,
  input logic cyc_start,
  input logic wen
);

  // R2: a store can only be launched while the latch is set
  p_start_needs_wen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |-> wen)
    else $error("store launched with latch clear");

  // R9: a launched store makes the block busy on the next cycle
  p_start_sets_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |=> busy)
    else $error("store launched without busy");

  // R9: busy status is reported as a driven 0
  p_busy_drives_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && do_oe_o) |-> !do_o)
    else $error("output not low while busy");

  // R11: no new store can launch while one is running
  p_no_start_while_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cyc_start)
    else $error("store accepted while busy");

endmodule

bind mw_eeprom mw_eeprom_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .do_o     (do_o),
  .do_oe_o  (do_oe_o),
  .busy     (busy),
  .cyc_start(cyc_start),
  .wen      (wen_q)
);

// File: tb/mw_eeprom_test.sv
module mw_eeprom_test;

  localparam int AW  = 6;
  localparam int DW  = 16;
  localparam int CYC = 200;
  localparam int H   = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0;
  logic sk = 1'b0;
  logic di = 1'b0;
  logic do_o;
  logic do_oe;

  always #5 clk = ~clk;

  mw_eeprom #(.ADDR_W(AW), .DATA_W(DW), .CYCLE_CLKS(CYC)) uut (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs_i   (cs),
    .sk_i   (sk),
    .di_i   (di),
    .do_o   (do_o),
    .do_oe_o(do_oe)
  );

  int checks = 0;
  int fails  = 0;
  int mem_m [64];
  bit wen_m = 1'b0;
  bit finished = 1'b0;

  // expected output enable: select line seen through two flop stages
  logic oe_d1, oe_d2;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_d1 <= 1'b0;
      oe_d2 <= 1'b0;
    end else begin
      oe_d1 <= cs;
      oe_d2 <= oe_d1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      checks++;
      if (do_oe !== oe_d2) begin
        fails++;
        $display("FAIL R10 output enable act=%0b exp=%0b", do_oe, oe_d2);
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sk_bit(input logic b);
    di = b;
    tick(H);
    sk = 1'b1;
    tick(H);
    sk = 1'b0;
  endtask

  task automatic send_bits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) sk_bit(v[i]);
  endtask

  // mode 0: proper window, 1: select drops one data bit early, 2: extra clock first
  task automatic cmd(input logic [1:0] op, input logic [5:0] a, input logic [15:0] d,
                     input int mode);
    bit has_d = (op == 2'b01) || (op == 2'b00 && a[5:4] == 2'b01);
    bit progs = (op == 2'b01) || (op == 2'b11) || (op == 2'b00 && a[5] != a[4]);
    cs = 1'b1;
    tick(H);
    send_bits({29'd0, 1'b1, op}, 3);
    send_bits({26'd0, a}, 6);
    if (has_d) begin
      for (int i = 15; i >= 0; i--) if (!(mode == 1 && i == 0)) sk_bit(d[i]);
    end
    if (mode == 2) sk_bit(1'b0);
    tick(H);
    cs = 1'b0;
    tick(4);
    if (op == 2'b00 && a[5:4] == 2'b11) wen_m = 1'b1;
    else if (op == 2'b00 && a[5:4] == 2'b00) wen_m = 1'b0;
    else if (progs && wen_m && mode == 0) begin
      if (op == 2'b01) mem_m[a] = d;
      else if (op == 2'b11) mem_m[a] = 16'hFFFF;
      else if (a[5:4] == 2'b01) for (int k = 0; k < 64; k++) mem_m[k] = d;
      else for (int k = 0; k < 64; k++) mem_m[k] = 16'hFFFF;
    end
    if (progs) tick(CYC + 20);
  endtask

  task automatic rd(input logic [5:0] a, input string req);
    logic [15:0] v;
    logic dummy;
    cs = 1'b1;
    tick(H);
    send_bits({29'd0, 3'b110}, 3);
    send_bits({27'd0, a[5:1]}, 5);
    di = a[0];
    tick(H);
    sk = 1'b1;
    tick(H);
    dummy = do_o;
    sk = 1'b0;
    for (int i = 15; i >= 0; i--) begin
      di = 1'b0;
      tick(H);
      sk = 1'b1;
      tick(H);
      v[i] = do_o;
      sk = 1'b0;
    end
    tick(H);
    cs = 1'b0;
    tick(4);
    chk({"R4 dummy bit / ", req}, {31'd0, dummy}, 32'd0);
    chk(req, {16'd0, v}, mem_m[a]);
  endtask

  initial begin
    for (int k = 0; k < 64; k++) mem_m[k] = 16'hFFFF;
    tick(5);
    rst_n = 1'b1;
    tick(5);

    // R1 reset state
    chk("R1 output disabled after reset", {31'd0, do_oe}, 32'd0);
    rd(6'd5, "R1 word reads erased after reset");
    rd(6'd63, "R1 top word reads erased after reset");

    // R2 latch clear blocks changes
    cmd(2'b01, 6'd5, 16'h1234, 0);
    rd(6'd5, "R2 write blocked before enable");
    cmd(2'b00, 6'b010000, 16'h0000, 0);
    rd(6'd9, "R2 fill-all blocked before enable");
    cmd(2'b00, 6'b110000, 16'h0, 0);

    // R5 write, R9 busy/ready, R11 frame during busy
    cs = 1'b1;
    tick(H);
    send_bits({29'd0, 3'b101}, 3);
    send_bits(32'd5, 6);
    send_bits(32'hA5C3, 16);
    tick(H);
    cs = 1'b0;
    mem_m[5] = 16'hA5C3;
    tick(3);
    cs = 1'b1;
    tick(6);
    chk("R9 busy drives 0", {31'd0, do_o}, 32'd0);
    chk("R10 enabled while selected", {31'd0, do_oe}, 32'd1);
    send_bits({29'd0, 3'b100}, 3);
    send_bits(32'd0, 6);
    tick(H);
    cs = 1'b0;
    tick(CYC + 20);
    cs = 1'b1;
    tick(6);
    chk("R9 ready drives 1", {31'd0, do_o}, 32'd1);
    cs = 1'b0;
    tick(4);
    rd(6'd5, "R5 write stored");
    cmd(2'b01, 6'd7, 16'h0F0F, 0);
    rd(6'd7, "R11 latch-clear during busy ignored");

    // R6 window misses
    cmd(2'b01, 6'd8, 16'h1111, 1);
    rd(6'd8, "R6 early select drop leaves word");
    cmd(2'b01, 6'd8, 16'h2222, 2);
    rd(6'd8, "R6 late select drop leaves word");

    // R7 erase
    cmd(2'b11, 6'd5, 16'h0, 0);
    rd(6'd5, "R7 erase sets ones");

    // R8 fill-all then erase-all
    cmd(2'b00, 6'b010000, 16'h5A5A, 0);
    rd(6'd0, "R8 fill-all word 0");
    rd(6'd63, "R8 fill-all word 63");
    rd(6'd7, "R8 fill-all word 7");
    cmd(2'b00, 6'b100000, 16'h0, 0);
    rd(6'd7, "R8 erase-all word 7");
    rd(6'd0, "R8 erase-all word 0");

    // R3 latch clear blocks again, R4 reads still work
    cmd(2'b01, 6'd3, 16'hBEEF, 0);
    cmd(2'b00, 6'b000000, 16'h0, 0);
    cmd(2'b01, 6'd3, 16'h0000, 0);
    rd(6'd3, "R3 write blocked after latch clear");
    cmd(2'b11, 6'd3, 16'h0, 0);
    rd(6'd3, "R3 erase blocked after latch clear");
    rd(6'd3, "R4 read while latch clear");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1500000;
    if (!finished) begin
      finished = 1'b1;
      fails++;
      checks++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule